// File: doc/BRIEF.md
# Asynchronous Strobe-Handshake Register Port

This block lets an external host processor read and write a small bank of 8-bit registers over an asynchronous, strobe-based bus. The host first presents a 7-bit address and pulses an active-low address strobe. The address is captured when that strobe returns high. The host then picks the direction with a read/write select and pulls an active-low data strobe. The block answers with an active-low acknowledge. The host keeps the data strobe low until it sees that acknowledge, and the cycle ends when the host lets the data strobe go high again. The block takes part in a cycle only while the active-low chip select is held.

All bus inputs, including the address and data lines, are brought into the internal clock domain through two-flop synchronizers. Every decision is made on edges of the synchronized strobes. The shared data bus is modelled as a separate output value and output enable, which a pad ring combines into a tristate driver. The enable is raised only for a read. An address that falls outside the implemented bank reads as zero and absorbs writes, but the handshake still completes.

Top module: `hostRegPort`

## Requirements
- R1: After reset the acknowledge output is high, the output enable is low and every register holds zero.
- R2: The address is captured on the rising edge of the synchronized address strobe, and only while the synchronized chip select is low. At any other time the captured address is kept.
- R3: A falling synchronized data strobe with chip select low and read/write select high (read) raises the output enable and presents the addressed register on the output data, three clock edges after the strobe input changes.
- R4: The acknowledge goes low exactly one clock after the read data and output enable become valid, provided data strobe and chip select are still held.
- R5: A falling synchronized data strobe with chip select low and read/write select low (write) stores the synchronized data input into the addressed register, and the acknowledge goes low one clock after that store.
- R6: Once the synchronized data strobe is high, the acknowledge is high and the output enable is low after the next clock.
- R7: Releasing chip select ends a cycle in the same way as releasing the data strobe. A data strobe pulse while chip select is high neither acknowledges, drives the bus, nor changes any register.
- R8: Addresses at or above the number of implemented registers (16 by default) read as zero, leave all registers unchanged on a write, and still receive the acknowledge.
- R9: When the address strobe rise and the data strobe fall are seen in the same synchronized cycle, the access uses the address captured in that cycle.
- R10: The output enable is never raised during a write cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock |
| rstN | input | 1 | Asynchronous active-low reset |
| asN | input | 1 | Address strobe, active low; address captured on its rise |
| csN | input | 1 | Chip select, active low |
| rwSel | input | 1 | 1 = read, 0 = write |
| dsN | input | 1 | Data strobe, active low |
| addrIn | input | 7 | Register address from the host |
| dataIn | input | 8 | Write data from the host |
| dataOut | output | 8 | Read data toward the bus driver |
| dataOe | output | 1 | Enable for the bus driver |
| dtackN | output | 1 | Acknowledge, active low |

## Verification
Two functions can land in the same internal cycle: address capture on the address strobe rise, and the start of a register access on the data strobe fall. The bench provokes this by releasing the address strobe and asserting the data strobe on the same input edge, after an earlier cycle has left a different address latched. It then checks that the returned data comes from the newly presented address and not the stale one. A behavioural model in the bench tracks the synchronizer delay and the handshake, and its outputs are compared against the port outputs on every clock, so any slip in the order of capture and access shows up in that very cycle.

// File: rtl/hostRegPkg.sv
package hostRegPkg;

  // Handshake phase of the control unit
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,  // waiting for a data strobe fall
    PH_SETTLE = 2'd1,  // data presented or stored, acknowledge next
    PH_HOLD   = 2'd2   // acknowledge asserted until release
  } phase_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic capAddr;  // latch the synchronized address
    logic rdLoad;   // load read data into the output register
    logic wrEn;     // commit write data into the register bank
  } strobe_t;

endpackage

// File: rtl/hostRegSync.sv
module hostRegSync #(
  parameter int              WIDTH   = 1,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stageQ [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stageQ[0] <= RST_VAL;
    else       stageQ[0] <= asyncIn;
  end

  for (genvar s = 1; s < STAGES; s++) begin : gStage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stageQ[s] <= RST_VAL;
      else       stageQ[s] <= stageQ[s-1];
    end
  end

  assign syncOut = stageQ[STAGES-1];

endmodule

// File: rtl/hostRegCtrl.sv
module hostRegCtrl
  import hostRegPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    asNS,    // synchronized address strobe
  input  logic    csNS,    // synchronized chip select
  input  logic    dsNS,    // synchronized data strobe
  input  logic    rdSel,   // synchronized read/write select
  output strobe_t strobes,
  output logic    dtackN,
  output logic    dataOe
);

  phase_e phaseQ;
  logic   asNPrev, dsNPrev;
  logic   asRise, dsFall, csAct, dsAct, released;

  // Edge detection on the synchronized strobes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      asNPrev <= 1'b1;
      dsNPrev <= 1'b1;
    end else begin
      asNPrev <= asNS;
      dsNPrev <= dsNS;
    end
  end

  assign asRise   = asNS & ~asNPrev;
  assign dsFall   = ~dsNS & dsNPrev;
  assign csAct    = ~csNS;
  assign dsAct    = ~dsNS;
  assign released = ~dsAct | ~csAct;

  // Strobes toward the datapath
  always_comb begin
    strobes         = '0;
    strobes.capAddr = asRise & csAct;
    if (phaseQ == PH_IDLE && dsFall && csAct) begin
      strobes.rdLoad = rdSel;
      strobes.wrEn   = ~rdSel;
    end
  end

  // Handshake sequencing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ <= PH_IDLE;
      dtackN <= 1'b1;
      dataOe <= 1'b0;
    end else if (released) begin
      phaseQ <= PH_IDLE;
      dtackN <= 1'b1;
      dataOe <= 1'b0;
    end else begin
      unique case (phaseQ)
        PH_IDLE: begin
          if (dsFall) begin
            phaseQ <= PH_SETTLE;
            dataOe <= rdSel;
          end
        end
        PH_SETTLE: begin
          phaseQ <= PH_HOLD;
          dtackN <= 1'b0;
        end
        PH_HOLD: phaseQ <= PH_HOLD;
        default: phaseQ <= PH_IDLE;
      endcase
    end
  end

  // The bus is only driven for a cycle that began as a read
  p_oe_read_only_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataOe) |-> $past(rdSel));

  // Release of either strobe drops acknowledge and enable next clock (R6, R7)
  p_release_ends_r6: assert property (@(posedge clk) disable iff (!rstN)
    (dsNS || csNS) |=> (dtackN && !dataOe));

  // Acknowledge follows valid read data by one clock
  p_ack_after_data_r4: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(dataOe) && !dsNS && !csNS) |=> !dtackN);

  // Acknowledge only appears while the host holds the cycle
  p_ack_needs_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dtackN) |-> $past(!dsNS && !csNS));

  // A single access is never both read and write
  p_excl_access_r5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.rdLoad, strobes.wrEn}));

endmodule

// File: rtl/hostRegData.sv
module hostRegData
  import hostRegPkg::*;
#(
  parameter int ADDR_W   = 7,
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic [ADDR_W-1:0] addrSync,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] dataOut
);

  localparam int                IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(NUM_REGS - 1);

  logic [ADDR_W-1:0]               addrQ;
  logic [ADDR_W-1:0]               effAddr;
  logic [IDX_W-1:0]                idx;
  logic                            inRange;
  logic [NUM_REGS-1:0][DATA_W-1:0] regFile;
  logic [DATA_W-1:0]               rdValue;

  // A capture in the same cycle as an access forwards the new address
  assign effAddr = strobes.capAddr ? addrSync : addrQ;
  assign idx     = effAddr[IDX_W-1:0];
  assign inRange = (effAddr <= LAST_IDX);
  assign rdValue = inRange ? regFile[idx] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                addrQ <= '0;
    else if (strobes.capAddr) addrQ <= addrSync;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regFile <= '0;
    end else if (strobes.wrEn && inRange) begin
      for (int i = 0; i < NUM_REGS; i++) begin
        if (idx == IDX_W'(i)) regFile[i] <= wrData;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               dataOut <= '0;
    else if (strobes.rdLoad) dataOut <= rdValue;
  end

  // Out-of-range reads present zero
  p_oob_reads_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.rdLoad && !inRange) |=> (dataOut == '0));

  // Out-of-range writes leave the bank untouched
  p_oob_write_ignored_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.wrEn && !inRange) |=> $stable(regFile));

  // Captured address only moves on a capture strobe
  p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.capAddr |=> $stable(addrQ));

endmodule

// File: rtl/hostRegPort.sv
module hostRegPort
  import hostRegPkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int NUM_REGS    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              asN,
  input  logic              csN,
  input  logic              rwSel,
  input  logic              dsN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic              dtackN
);

  localparam int BUS_W = ADDR_W + DATA_W;

  logic [3:0]        ctlSync;
  logic [BUS_W-1:0]  busSync;
  strobe_t           strobes;

  // Strobes idle high after reset; read/write select idles as read
  hostRegSync #(.WIDTH(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1111)) u_ctlSync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn ({asN, csN, dsN, rwSel}),
    .syncOut (ctlSync)
  );

  hostRegSync #(.WIDTH(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_busSync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn ({addrIn, dataIn}),
    .syncOut (busSync)
  );

  hostRegCtrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .asNS    (ctlSync[3]),
    .csNS    (ctlSync[2]),
    .dsNS    (ctlSync[1]),
    .rdSel   (ctlSync[0]),
    .strobes (strobes),
    .dtackN  (dtackN),
    .dataOe  (dataOe)
  );

  hostRegData #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_data (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .addrSync (busSync[BUS_W-1:DATA_W]),
    .wrData   (busSync[DATA_W-1:0]),
    .dataOut  (dataOut)
  );

endmodule

// File: tb/hostRegPort_bench.sv
module hostRegPort_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       asN = 1'b1, csN = 1'b1, rwSel = 1'b1, dsN = 1'b1;
  logic [6:0] addrIn = '0;
  logic [7:0] dataIn = '0;
  logic [7:0] dataOut;
  logic       dataOe, dtackN;

  int testsRun = 0;
  int testsFailed = 0;
  int cycleCount = 0;

  always #2 clk = ~clk;  // 250 MHz

  hostRegPort u_hostRegPort (
    .clk(clk), .rstN(rstN), .asN(asN), .csN(csN), .rwSel(rwSel), .dsN(dsN),
    .addrIn(addrIn), .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe),
    .dtackN(dtackN)
  );

  // Behavioural reference model
  int   mRegs [16];
  logic [3:0]  mC1, mC2;   // {asN, csN, dsN, rwSel} pipeline
  logic [14:0] mD1, mD2;   // {addr, data} pipeline
  logic mAsP, mDsP;
  int   mAddr, mPhase;
  logic mOe, mAck;
  logic [7:0] mData;

  always @(posedge clk) begin
    if (!rstN) begin
      foreach (mRegs[i]) mRegs[i] = 0;
      mC1 = 4'b1111; mC2 = 4'b1111; mD1 = '0; mD2 = '0;
      mAsP = 1'b1; mDsP = 1'b1; mAddr = 0; mPhase = 0;
      mOe = 1'b0; mAck = 1'b0; mData = '0;
    end else begin
      logic asRise, dsFall, csAct, dsAct;
      int   effA;
      asRise = mC2[3] && !mAsP;
      dsFall = !mC2[1] && mDsP;
      csAct  = !mC2[2];
      dsAct  = !mC2[1];
      effA   = (asRise && csAct) ? int'(mD2[14:8]) : mAddr;
      if (!dsAct || !csAct) begin
        mPhase = 0; mOe = 1'b0; mAck = 1'b0;
      end else if (mPhase == 0) begin
        if (dsFall) begin
          if (mC2[0]) begin
            mOe = 1'b1;
            mData = (effA < 16) ? 8'(mRegs[effA]) : 8'h00;
          end else if (effA < 16) begin
            mRegs[effA] = int'(mD2[7:0]);
          end
          mPhase = 1;
        end
      end else if (mPhase == 1) begin
        mAck = 1'b1; mPhase = 2;
      end
      if (asRise && csAct) mAddr = int'(mD2[14:8]);
      mAsP = mC2[3]; mDsP = mC2[1];
      mC2 = mC1; mC1 = {asN, csN, dsN, rwSel};
      mD2 = mD1; mD1 = {addrIn, dataIn};
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycleCount);
    end
  endtask

  // Per-clock comparison against the model, away from the active edge
  always @(negedge clk) begin
    cycleCount++;
    if (rstN) begin
      check(dtackN == !mAck, "R4/R6 acknowledge vs model", int'(dtackN), int'(!mAck));
      check(dataOe == mOe, "R3/R10 output enable vs model", int'(dataOe), int'(mOe));
      if (mOe) check(dataOut == mData, "R3 read data vs model", int'(dataOut), int'(mData));
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(negedge clk);
    testsFailed++;
    testsRun++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic waitAck(input logic level, input string tag);
    int n = 0;
    while (dtackN != level && n < 30) begin
      @(negedge clk);
      n++;
    end
    check(dtackN == level, tag, int'(dtackN), int'(level));
  endtask

  task automatic setAddr(input logic [6:0] a);
    @(negedge clk);
    addrIn = a; csN = 1'b0; asN = 1'b0;
    waitClk(3);
    asN = 1'b1;
    waitClk(3);
  endtask

  task automatic hostRead(input logic [6:0] a, input logic [7:0] exp, input string tag);
    setAddr(a);
    rwSel = 1'b1; dsN = 1'b0;
    waitAck(1'b0, "R4 read acknowledge arrives");
    check(dataOe == 1'b1, "R3 enable during read", int'(dataOe), 1);
    check(dataOut == exp, tag, int'(dataOut), int'(exp));
    dsN = 1'b1;
    waitAck(1'b1, "R6 acknowledge released");
    waitClk(1);
    check(dataOe == 1'b0, "R6 enable cleared", int'(dataOe), 0);
    csN = 1'b1;
    waitClk(2);
  endtask

  task automatic hostWrite(input logic [6:0] a, input logic [7:0] d);
    setAddr(a);
    rwSel = 1'b0; dataIn = d; dsN = 1'b0;
    waitAck(1'b0, "R5 write acknowledge arrives");
    check(dataOe == 1'b0, "R10 no drive in write", int'(dataOe), 0);
    dsN = 1'b1;
    waitAck(1'b1, "R6 acknowledge released after write");
    csN = 1'b1; rwSel = 1'b1;
    waitClk(2);
  endtask

  initial begin
    waitClk(3);
    check(dtackN == 1'b1, "R1 acknowledge high in reset", int'(dtackN), 1);
    check(dataOe == 1'b0, "R1 enable low in reset", int'(dataOe), 0);
    @(negedge clk) rstN = 1'b1;
    waitClk(2);

    hostRead(7'd3, 8'h00, "R1 register zero after reset");
    hostRead(7'd15, 8'h00, "R1 top register zero after reset");

    // Plain writes and read-backs
    hostWrite(7'd3, 8'hA5);
    hostRead(7'd3, 8'hA5, "R5 write then read");
    hostWrite(7'd0, 8'h11);
    hostWrite(7'd15, 8'hF0);
    hostWrite(7'd5, 8'h3C);
    hostWrite(7'd2, 8'h5A);
    hostRead(7'd0, 8'h11, "R3 read register 0");
    hostRead(7'd15, 8'hF0, "R3 read last register");
    hostRead(7'd3, 8'hA5, "R2 register 3 untouched by others");

    // Out-of-range access
    hostWrite(7'd100, 8'hFF);
    hostRead(7'd100, 8'h00, "R8 out-of-range reads zero");
    hostRead(7'd16, 8'h00, "R8 first out-of-range reads zero");
    hostRead(7'd0, 8'h11, "R8 out-of-range write left register 0");

    // Strobes with chip select released: no capture, no access
    @(negedge clk);
    csN = 1'b1; addrIn = 7'd2; asN = 1'b0;
    waitClk(3); asN = 1'b1; waitClk(3);
    rwSel = 1'b0; dataIn = 8'h77; dsN = 1'b0;
    waitClk(10);
    check(dtackN == 1'b1, "R7 no acknowledge without chip select", int'(dtackN), 1);
    check(dataOe == 1'b0, "R7 no drive without chip select", int'(dataOe), 0);
    dsN = 1'b1; rwSel = 1'b1;
    waitClk(3);
    hostRead(7'd2, 8'h5A, "R7 register unchanged without chip select");

    // Chip select dropped mid-cycle ends the read
    setAddr(7'd3);
    rwSel = 1'b1; dsN = 1'b0;
    waitAck(1'b0, "R4 acknowledge before abort");
    csN = 1'b1;
    waitClk(3);
    check(dtackN == 1'b1, "R7 acknowledge released by chip select", int'(dtackN), 1);
    check(dataOe == 1'b0, "R7 enable released by chip select", int'(dataOe), 0);
    dsN = 1'b1;
    waitClk(3);

    // Address capture and data strobe fall in the same cycle (stale address is 3)
    hostRead(7'd3, 8'hA5, "R9 setup stale address");
    @(negedge clk);
    addrIn = 7'd5; csN = 1'b0; asN = 1'b0; rwSel = 1'b1;
    waitClk(4);
    asN = 1'b1; dsN = 1'b0;
    waitAck(1'b0, "R9 acknowledge for same-cycle access");
    check(dataOut == 8'h3C, "R9 same-cycle capture uses new address", int'(dataOut), 8'h3C);
    dsN = 1'b1;
    waitAck(1'b1, "R6 release after same-cycle access");
    csN = 1'b1;
    waitClk(3);

    // Same-cycle capture on a write
    @(negedge clk);
    addrIn = 7'd7; csN = 1'b0; asN = 1'b0; rwSel = 1'b0; dataIn = 8'hC3;
    waitClk(4);
    asN = 1'b1; dsN = 1'b0;
    waitAck(1'b0, "R9 acknowledge for same-cycle write");
    dsN = 1'b1;
    waitAck(1'b1, "R6 release after same-cycle write");
    csN = 1'b1; rwSel = 1'b1;
    waitClk(3);
    hostRead(7'd7, 8'hC3, "R9 same-cycle write hit new address");
    hostRead(7'd5, 8'h3C, "R9 stale address not written");

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule